// File: doc/BRIEF.md
# Command-Processor Microcontroller ALU

This block is the arithmetic and logic unit of a small 32-bit command-processing microcontroller. Each cycle it takes a 4-bit opcode, a first operand and a second operand. The second operand is either a register value or a 16-bit immediate taken from the instruction. It returns a 32-bit result combinationally, in the same cycle.

The supported operations are:
- add and subtract;
- bitwise logic;
- logical and arithmetic right shifts, a left shift and a left rotate;
- a multiply of the low bytes;
- unsigned minimum and maximum;
- a three-way compare.

The compare returns fixed codes. Their bits are chosen so that a branch testing a single bit can decide greater, less, less-or-equal or greater-or-equal.

A one-bit carry flag sits between consecutive operations. Plain add and subtract leave their carry or borrow in the flag. The "hi" variants consume that flag, so a 64-bit value can be processed as a low half followed by a high half. The flag changes only at a clock edge on which the execute strobe is high. Instruction fetch, decoding of the instruction word and the register file live outside this block.

Top module: `mcu_alu`

## Requirements
- R1: When `use_imm_i` is 1, the second operand is `imm_i` zero-extended to 32 bits. When it is 0, the second operand is `src2_i`.
- R2: With `a` as the first operand and `b` as the second, these opcodes give their result modulo 2^32:
  - 0 (add): a+b
  - 2 (sub): a-b
  - 4 (and): a&b
  - 5 (or): a|b
  - 6 (xor): a^b
- R3: Opcode 7 (not) returns ~b. It uses only the second operand, so register and immediate forms both work.
- R4: The shifts use only the low 5 bits of the second operand as the amount:
  - opcode 8 shifts left with zero fill;
  - opcode 9 shifts right with zero fill;
  - opcode 10 shifts right and fills with bit 31.
- R5: Opcode 11 rotates the first operand left by the low 5 bits of the second operand. Bits shifted out at the top re-enter at bit 0.
- R6: Opcode 12 multiplies bits 7:0 of both operands. The 16-bit product is zero-extended to 32 bits.
- R7: Opcode 13 returns the unsigned minimum of the two operands and opcode 14 returns the unsigned maximum.
- R8: Opcode 15 compares the operands as unsigned values. It returns 0x00 when a > b, 0x2b when a == b and 0x1e when a < b. Result bit 1 is therefore set exactly when a <= b.
- R9: The carry flag is updated on a rising clock edge on which `exec_i` is 1 and the opcode is one of the following:
  - opcode 0 (add): the flag takes the carry out of a+b;
  - opcode 2 (sub): the flag takes the borrow, a < b;
  - opcode 1 (addhi): the result is a+b+flag, and the flag takes the carry out of that sum;
  - opcode 3 (subhi): the result is a-b-flag, and the flag takes its borrow.
- R10: Reset clears the carry flag to 0. The flag keeps its value when `exec_i` is 0 and for every opcode other than 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Operation executes this cycle (enables the flag update) |
| op_i | input | 4 | Operation code |
| src1_i | input | 32 | First operand |
| src2_i | input | 32 | Second operand, register form |
| imm_i | input | 16 | Second operand, immediate form |
| use_imm_i | input | 1 | Selects the immediate as the second operand |
| result_o | output | 32 | Combinational result |
| carry_o | output | 1 | Carry/borrow flag |

## Verification
The clocked properties assume that the opcode, the operands and `exec_i` are stable across each rising edge. They also assume the inputs are never unknown while reset is released. The flag properties additionally take the sampled operands to be the ones that produced the result. The bench meets these assumptions by changing every input only on the falling edge and driving defined values from time zero. Each flag update is a single-cycle `exec_i` pulse whose inputs are held until the following falling edge.

// File: rtl/mcu_alu_pkg.sv
package mcu_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDHI = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBHI = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_NOT   = 4'd7,
    OP_SHL   = 4'd8,
    OP_USHR  = 4'd9,
    OP_ISHR  = 4'd10,
    OP_ROT   = 4'd11,
    OP_MUL8  = 4'd12,
    OP_MIN   = 4'd13,
    OP_MAX   = 4'd14,
    OP_CMP   = 4'd15
  } alu_op_e;

  localparam int CMP_CODE_W = 6;
  localparam logic [CMP_CODE_W-1:0] CMP_GT = 6'h00;
  localparam logic [CMP_CODE_W-1:0] CMP_EQ = 6'h2b;
  localparam logic [CMP_CODE_W-1:0] CMP_LT = 6'h1e;

  // Ops that write the carry flag.
  function automatic logic is_carry_op(alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADDHI) || (op == OP_SUB) || (op == OP_SUBHI);
  endfunction

endpackage

// File: rtl/mcu_alu_opsel.sv
module mcu_alu_opsel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] opnd_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    if (use_imm_i) opnd_o = {{PAD_W{1'b0}}, imm_i};
    else           opnd_o = reg_i;
  end
endmodule

// File: rtl/mcu_alu_core.sv
module mcu_alu_core
  import mcu_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MUL_W  = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_o
);
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int PROD_W  = 2 * MUL_W;
  localparam int EXT_W   = DATA_W + 1;

  function automatic logic [EXT_W-1:0] f_addc(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b, logic ci);
    return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
  endfunction

  // Bit DATA_W of the 33-bit wrap is the borrow.
  function automatic logic [EXT_W-1:0] f_subb(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b, logic bi);
    return {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, bi};
  endfunction

  function automatic logic [DATA_W-1:0] f_rotl(logic [DATA_W-1:0] a, logic [SHAMT_W-1:0] s);
    logic [2*DATA_W-1:0] dbl;
    dbl = {a, a} << s;
    return dbl[2*DATA_W-1:DATA_W];
  endfunction

  function automatic logic [DATA_W-1:0] f_mul(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    logic [PROD_W-1:0] p;
    p = PROD_W'(a[MUL_W-1:0]) * PROD_W'(b[MUL_W-1:0]);
    return {{(DATA_W-PROD_W){1'b0}}, p};
  endfunction

  function automatic logic [DATA_W-1:0] f_cmp(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    logic [CMP_CODE_W-1:0] c;
    if (a > b)       c = CMP_GT;
    else if (a == b) c = CMP_EQ;
    else             c = CMP_LT;
    return {{(DATA_W-CMP_CODE_W){1'b0}}, c};
  endfunction

  logic [SHAMT_W-1:0] shamt;
  logic [EXT_W-1:0]   sum_w, diff_w;
  logic               chain_in;

  assign shamt    = b_i[SHAMT_W-1:0];
  assign chain_in = ((op_i == OP_ADDHI) || (op_i == OP_SUBHI)) ? flag_i : 1'b0;
  assign sum_w    = f_addc(a_i, b_i, chain_in);
  assign diff_w   = f_subb(a_i, b_i, chain_in);

  always_comb begin
    flag_o = flag_i;
    unique case (op_i)
      OP_ADD, OP_ADDHI: begin result_o = sum_w[DATA_W-1:0];  flag_o = sum_w[DATA_W];  end
      OP_SUB, OP_SUBHI: begin result_o = diff_w[DATA_W-1:0]; flag_o = diff_w[DATA_W]; end
      OP_AND:  result_o = a_i & b_i;
      OP_OR:   result_o = a_i | b_i;
      OP_XOR:  result_o = a_i ^ b_i;
      OP_NOT:  result_o = ~b_i;
      OP_SHL:  result_o = a_i << shamt;
      OP_USHR: result_o = a_i >> shamt;
      OP_ISHR: result_o = $unsigned($signed(a_i) >>> shamt);
      OP_ROT:  result_o = f_rotl(a_i, shamt);
      OP_MUL8: result_o = f_mul(a_i, b_i);
      OP_MIN:  result_o = (a_i < b_i) ? a_i : b_i;
      OP_MAX:  result_o = (a_i > b_i) ? a_i : b_i;
      OP_CMP:  result_o = f_cmp(a_i, b_i);
      default: result_o = '0;
    endcase
  end
endmodule

// File: rtl/mcu_alu_flag.sv
module mcu_alu_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic nxt_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (upd_i) flag_o <= nxt_i;
  end
endmodule

// File: rtl/mcu_alu.sv
module mcu_alu
  import mcu_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int MUL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] opnd_b;
  logic              flag_nxt;
  logic              flag_upd;

  assign op       = alu_op_e'(op_i);
  assign flag_upd = exec_i && is_carry_op(op);

  mcu_alu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .reg_i(src2_i), .imm_i(imm_i), .use_imm_i(use_imm_i), .opnd_o(opnd_b)
  );

  mcu_alu_core #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_core (
    .op_i(op), .a_i(src1_i), .b_i(opnd_b), .flag_i(carry_o),
    .result_o(result_o), .flag_o(flag_nxt)
  );

  mcu_alu_flag u_flag (
    .clk(clk), .rst_n(rst_n), .upd_i(flag_upd), .nxt_i(flag_nxt), .flag_o(carry_o)
  );

  // R1
  imm_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_imm_i |-> (opnd_b[DATA_W-1:IMM_W] == '0));

  // R8
  cmp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP) |-> (result_o == DATA_W'(CMP_GT) || result_o == DATA_W'(CMP_EQ)
                        || result_o == DATA_W'(CMP_LT)));

  // R8
  cmp_le_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP) |-> (result_o[1] == (src1_i <= opnd_b)));

  // R6
  mul_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MUL8) |-> (result_o[DATA_W-1:2*MUL_W] == '0));

  // R7
  min_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MIN) |-> (result_o <= src1_i && result_o <= opnd_b));

  // R9
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op == OP_ADD) |=> (carry_o == ($past(result_o) < $past(src1_i))));

  // R9
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op == OP_SUB) |=> (carry_o == ($past(src1_i) < $past(opnd_b))));

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_i && is_carry_op(op)) |=> $stable(carry_o));
endmodule

// File: tb/test_mcu_alu.sv
`timescale 1ns/1ps
module test_mcu_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_i = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [31:0] src1_i = '0, src2_i = '0;
  logic [15:0] imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mcu_alu i_mcu_alu (.*);

  localparam int NV = 20;
  localparam logic [3:0]  T_OP  [NV] = '{4'd0, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11,
                                         4'd11, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15, 4'd15, 4'd15, 4'd15, 4'd1};
  localparam logic [31:0] T_A   [NV] = '{32'hFFFF_FFFF, 32'h5, 32'hF0F0_1234, 32'h8000_0000, 32'hAAAA_AAAA,
                                         32'h0, 32'h3, 32'h8000_0000, 32'h8000_0010, 32'h8000_0001,
                                         32'h1234_5678, 32'h1234_5678, 32'h1234_56FF, 32'h8000_0000, 32'h8000_0000,
                                         32'h5, 32'h3, 32'h1, 32'h0001_0000, 32'h1};
  localparam logic [31:0] T_B   [NV] = '{32'h2, 32'h7, 32'h0, 32'h0, 32'hFFFF_0000,
                                         32'h0, 32'h24, 32'h0, 32'h4, 32'h0,
                                         32'h0, 32'h8, 32'hABCD_EFFF, 32'h1, 32'h1,
                                         32'h3, 32'h3, 32'hFFFF_FFFF, 32'h0, 32'h2};
  localparam logic [15:0] T_IMM [NV] = '{16'h0, 16'h0, 16'hFF00, 16'h00FF, 16'h0,
                                         16'h1234, 16'h0, 16'd31, 16'h0, 16'h1,
                                         16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
                                         16'h0, 16'h0, 16'h0, 16'hFFFF, 16'h0};
  localparam logic        T_UI  [NV] = '{0,0,1,1,0, 1,0,1,0,1, 0,0,0,0,0, 0,0,0,1,0};
  localparam logic [31:0] T_EXP [NV] = '{32'h1, 32'hFFFF_FFFE, 32'h0000_1200, 32'h8000_00FF, 32'h5555_AAAA,
                                         32'hFFFF_EDCB, 32'h30, 32'h1, 32'hF800_0001, 32'h3,
                                         32'h1234_5678, 32'h3456_7812, 32'h0000_FE01, 32'h1, 32'h8000_0000,
                                         32'h0, 32'h2B, 32'h1E, 32'h0, 32'h3};

  function automatic string req_of(logic [3:0] op, logic ui);
    if (ui) return "R1";
    case (op)
      4'd0, 4'd2, 4'd4, 4'd5, 4'd6: return "R2";
      4'd7: return "R3";
      4'd8, 4'd9, 4'd10: return "R4";
      4'd11: return "R5";
      4'd12: return "R6";
      4'd13, 4'd14: return "R7";
      4'd15: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [15:0] imm, logic ui);
    @(negedge clk);
    op_i = op; src1_i = a; src2_i = b; imm_i = imm; use_imm_i = ui;
    #1;
  endtask

  // One-cycle execute pulse; returns after the edge has updated the flag.
  task automatic pulse(bit en);
    exec_i = en;
    @(negedge clk);
    exec_i = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset flag", {31'b0, carry_o}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(T_OP[i], T_A[i], T_B[i], T_IMM[i], T_UI[i]);
      chk(req_of(T_OP[i], T_UI[i]), result_o, T_EXP[i]);
    end

    // R8 bit 1 reflects less-or-equal
    drive(4'd15, 32'h3, 32'h3, 16'h0, 1'b0);
    chk("R8 le bit", {31'b0, result_o[1]}, 32'h1);
    drive(4'd15, 32'h5, 32'h3, 16'h0, 1'b0);
    chk("R8 gt bit", {31'b0, result_o[1]}, 32'h0);

    // R9 64-bit add: 0x1_FFFFFFFF + 0x2_00000001
    drive(4'd0, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0);
    chk("R9 add lo", result_o, 32'h0);
    pulse(1);
    chk("R9 add carry", {31'b0, carry_o}, 32'h1);
    drive(4'd1, 32'h1, 32'h2, 16'h0, 1'b0);
    chk("R9 addhi", result_o, 32'h4);

    // R10 hold: other op executed, and add without exec
    drive(4'd6, 32'h1, 32'h1, 16'h0, 1'b0);
    pulse(1);
    chk("R10 hold xor", {31'b0, carry_o}, 32'h1);
    drive(4'd0, 32'h1, 32'h1, 16'h0, 1'b0);
    pulse(0);
    chk("R10 hold noexec", {31'b0, carry_o}, 32'h1);
    drive(4'd1, 32'h10, 32'h20, 16'h0, 1'b0);
    chk("R9 addhi cin", result_o, 32'h31);
    pulse(1);
    chk("R9 addhi cout0", {31'b0, carry_o}, 32'h0);

    // R9 borrow chain
    drive(4'd2, 32'h3, 32'h5, 16'h0, 1'b0);
    pulse(1);
    chk("R9 sub borrow", {31'b0, carry_o}, 32'h1);
    drive(4'd3, 32'hA, 32'h2, 16'h0, 1'b0);
    chk("R9 subhi", result_o, 32'h7);
    drive(4'd3, 32'h0, 32'h0, 16'h0, 1'b0);
    chk("R9 subhi wrap", result_o, 32'hFFFF_FFFF);
    pulse(1);
    chk("R9 subhi bout", {31'b0, carry_o}, 32'h1);
    drive(4'd3, 32'h9, 32'h2, 16'h0, 1'b1);
    pulse(1);
    chk("R9 subhi clear", {31'b0, carry_o}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule